// File: doc/BRIEF.md
# Credit-Limited Multi-Channel Read Mover

This block sits between a banked memory and the read port of an accelerator. An upstream address generator hands it one address step at a time. Each step carries one address per lane. The mover raises one read request per memory channel for that step, using a valid/ready request handshake. It takes the next step only once every lane has issued.

The memory answers each request with data and a valid flag, and it has no way to be stalled. The mover therefore never issues a request unless the response is sure to find room. Each lane keeps a credit count: requests in flight plus words already buffered. A lane issues only while that count is below the FIFO depth.

Responses land in one in-order FIFO per lane. When every lane FIFO holds a word, the lane words are placed side by side and offered to the accelerator as one wide word on a valid/ready stream. Each accepted word pops every lane once.

Top module: `rd_lane_mover`

## Requirements
- R1: Once a lane raises its request valid while its ready is low, that lane keeps valid high and its address unchanged in the next cycle.
- R2: For each accepted address step, every lane issues exactly one request. Lane l uses address slice `[l*ADDR_W +: ADDR_W]` of the step. Every request has write flag 0, write data 0 and all strobe bits 1.
- R3: In each lane, requests issued minus words popped never exceeds DEPTH. A lane's request valid is low whenever this count equals DEPTH, even with a step pending.
- R4: A response is accepted in the cycle it arrives, with no ready signal, and no response word is lost or duplicated.
- R5: The step input is ready when no step is held, or when every lane has issued for the held step (earlier or in the current cycle). Otherwise it is not ready.
- R6: The output valid is high exactly when every lane FIFO holds at least one word. Lane l's word is placed at output bits `[l*LANE_W +: LANE_W]`.
- R7: Within each lane, response words leave in the order their requests were issued, so output word n holds the responses to step n.
- R8: While the output valid is high and its ready is low, the valid stays high and the data stays unchanged. Each output handshake removes exactly one word from every lane.
- R9: During and right after reset, no request valid is high, the output valid is low and the step input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_valid_i | input | 1 | Address step offered by the generator |
| step_ready_o | output | 1 | Address step accepted |
| step_addr_i | input | LANES*ADDR_W | One address per lane, lane l at slice l |
| mem_req_addr_o | output | LANES*ADDR_W | Request address per channel |
| mem_req_wdata_o | output | LANES*LANE_W | Request write data (always zero) |
| mem_req_write_o | output | LANES | Request write flag, 1 = write (always 0) |
| mem_req_strb_o | output | LANES*LANE_W/8 | Request byte strobe (all ones) |
| mem_req_valid_o | output | LANES | Request valid per channel |
| mem_req_ready_i | input | LANES | Request ready per channel |
| mem_rsp_data_i | input | LANES*LANE_W | Response data per channel |
| mem_rsp_valid_i | input | LANES | Response valid per channel, no backpressure |
| out_data_o | output | LANES*LANE_W | Joined accelerator word |
| out_valid_o | output | 1 | Joined word available |
| out_ready_i | input | 1 | Accelerator accepts the joined word |

## Verification
The hardest state to reach is credit saturation with words still in flight. A lane has used every credit, but some of those credits belong to responses that have not yet returned. A further step is then already waiting in the step register. The bench reaches this by holding the accelerator ready low for forty cycles while memory latency is long. During that window it confirms that each lane stops after exactly DEPTH requests. It then releases the output and checks that all data drains intact. The rest of the sweep crosses address wrap, lane and step strides, response latency and per-lane ready patterns. It checks the exact request-valid, step-ready and output-valid values in every cycle against counts kept in the bench.

// File: rtl/rd_mover_pkg.sv
package rd_mover_pkg;

   // Bits needed to count from 0 up to and including depth.
   function automatic int unsigned cnt_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   // Storage style for a lane queue, picked from its depth.
   typedef enum logic [0:0] {
      FIFO_REG  = 1'b0,
      FIFO_RING = 1'b1
   } fifo_kind_e;

endpackage

// File: rtl/rd_lane_fifo.sv
module rd_lane_fifo
   import rd_mover_pkg::*;
#(
   parameter int unsigned WIDTH = 64,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] data_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam fifo_kind_e KIND = (DEPTH == 1) ? FIFO_REG : FIFO_RING;

   generate
      if (KIND == FIFO_REG) begin : g_reg
         logic             held_q;
         logic [WIDTH-1:0] word_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               held_q <= 1'b0;
            end else if (pop_i && held_q) begin
               held_q <= 1'b0;
            end else if (push_i && !held_q) begin
               held_q <= 1'b1;
            end
         end

         always_ff @(posedge clk_i) begin
            if (push_i && !held_q) begin
               word_q <= data_i;
            end
         end

         assign data_o  = word_q;
         assign empty_o = !held_q;
         assign full_o  = held_q;
      end else begin : g_ring
         localparam int unsigned PW = $clog2(DEPTH);
         localparam int unsigned CW = cnt_bits(DEPTH);

         logic [WIDTH-1:0] slot_q [DEPTH];
         logic [PW-1:0]    wr_q;
         logic [PW-1:0]    rd_q;
         logic [CW-1:0]    fill_q;
         logic             do_push;
         logic             do_pop;

         function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         assign do_push = push_i && (fill_q != CW'(DEPTH));
         assign do_pop  = pop_i && (fill_q != '0);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               wr_q   <= '0;
               rd_q   <= '0;
               fill_q <= '0;
            end else begin
               if (do_push) begin
                  wr_q <= bump(wr_q);
               end
               if (do_pop) begin
                  rd_q <= bump(rd_q);
               end
               fill_q <= fill_q + CW'(do_push) - CW'(do_pop);
            end
         end

         always_ff @(posedge clk_i) begin
            if (do_push) begin
               slot_q[wr_q] <= data_i;
            end
         end

         assign data_o  = slot_q[rd_q];
         assign empty_o = (fill_q == '0);
         assign full_o  = (fill_q == CW'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/rd_lane_credit.sv
module rd_lane_credit
   import rd_mover_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CW    = cnt_bits(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          take_i,
   input  logic          give_i,
   output logic [CW-1:0] count_o,
   output logic          room_o
);

   logic [CW-1:0] count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + CW'(take_i) - CW'(give_i);
      end
   end

   assign count_o = count_q;
   assign room_o  = (count_q < CW'(DEPTH));

endmodule

// File: rtl/rd_mover_lane.sv
module rd_mover_lane
   import rd_mover_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned CW     = cnt_bits(DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_live_i,
   input  logic [ADDR_W-1:0] step_addr_i,
   input  logic              advance_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic              done_o,
   input  logic              rsp_valid_i,
   input  logic [LANE_W-1:0] rsp_data_i,
   input  logic              pop_i,
   output logic [LANE_W-1:0] head_o,
   output logic              empty_o,
   output logic              full_o,
   output logic [CW-1:0]     credit_o
);

   logic issued_q;
   logic room;
   logic fire;

   assign req_valid_o = step_live_i && !issued_q && room;
   assign req_addr_o  = step_addr_i;
   assign fire        = req_valid_o && req_ready_i;
   assign done_o      = issued_q || fire;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         issued_q <= 1'b0;
      end else if (advance_i) begin
         issued_q <= 1'b0;
      end else if (fire) begin
         issued_q <= 1'b1;
      end
   end

   rd_lane_credit #(
      .DEPTH (DEPTH),
      .CW    (CW)
   ) u_credit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (fire),
      .give_i  (pop_i),
      .count_o (credit_o),
      .room_o  (room)
   );

   rd_lane_fifo #(
      .WIDTH (LANE_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (rsp_valid_i),
      .data_i  (rsp_data_i),
      .pop_i   (pop_i),
      .data_o  (head_o),
      .empty_o (empty_o),
      .full_o  (full_o)
   );

endmodule

// File: rtl/rd_lane_mover.sv
module rd_lane_mover
   import rd_mover_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       step_valid_i,
   output logic                       step_ready_o,
   input  logic [LANES*ADDR_W-1:0]    step_addr_i,
   output logic [LANES*ADDR_W-1:0]    mem_req_addr_o,
   output logic [LANES*LANE_W-1:0]    mem_req_wdata_o,
   output logic [LANES-1:0]           mem_req_write_o,
   output logic [LANES*LANE_W/8-1:0]  mem_req_strb_o,
   output logic [LANES-1:0]           mem_req_valid_o,
   input  logic [LANES-1:0]           mem_req_ready_i,
   input  logic [LANES*LANE_W-1:0]    mem_rsp_data_i,
   input  logic [LANES-1:0]           mem_rsp_valid_i,
   output logic [LANES*LANE_W-1:0]    out_data_o,
   output logic                       out_valid_o,
   input  logic                       out_ready_i
);

   localparam int unsigned CW = cnt_bits(DEPTH);

   initial begin
      assert (LANES >= 1) else $error("rd_lane_mover: LANES must be at least 1");
      assert (LANE_W >= 8 && (LANE_W % 8) == 0) else $error("rd_lane_mover: LANE_W must be whole bytes");
      assert (ADDR_W >= 1) else $error("rd_lane_mover: ADDR_W must be at least 1");
      assert (DEPTH >= 1) else $error("rd_lane_mover: DEPTH must be at least 1");
   end

   logic                    step_live_q;
   logic [LANES*ADDR_W-1:0] step_addr_q;
   logic [LANES-1:0]        lane_done;
   logic [LANES-1:0]        lane_empty;
   logic [LANES-1:0]        lane_full;
   logic [LANES*CW-1:0]     lane_credit;
   logic                    all_done;
   logic                    advance;
   logic                    pop;

   assign all_done     = &lane_done;
   assign advance      = step_live_q && all_done;
   assign step_ready_o = !step_live_q || all_done;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_live_q <= 1'b0;
      end else if (step_valid_i && step_ready_o) begin
         step_live_q <= 1'b1;
      end else if (advance) begin
         step_live_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (step_valid_i && step_ready_o) begin
         step_addr_q <= step_addr_i;
      end
   end

   assign mem_req_wdata_o = '0;
   assign mem_req_write_o = '0;
   assign mem_req_strb_o  = '1;

   assign out_valid_o = ~|lane_empty;
   assign pop         = out_valid_o && out_ready_i;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         rd_mover_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W),
            .DEPTH  (DEPTH),
            .CW     (CW)
         ) u_lane (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .step_live_i (step_live_q),
            .step_addr_i (step_addr_q[l*ADDR_W +: ADDR_W]),
            .advance_i   (advance),
            .req_valid_o (mem_req_valid_o[l]),
            .req_ready_i (mem_req_ready_i[l]),
            .req_addr_o  (mem_req_addr_o[l*ADDR_W +: ADDR_W]),
            .done_o      (lane_done[l]),
            .rsp_valid_i (mem_rsp_valid_i[l]),
            .rsp_data_i  (mem_rsp_data_i[l*LANE_W +: LANE_W]),
            .pop_i       (pop),
            .head_o      (out_data_o[l*LANE_W +: LANE_W]),
            .empty_o     (lane_empty[l]),
            .full_o      (lane_full[l]),
            .credit_o    (lane_credit[l*CW +: CW])
         );
      end
   endgenerate

endmodule

// File: rtl/rd_lane_mover_chk.sv
module rd_lane_mover_chk
   import rd_mover_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic [LANES-1:0]        req_valid,
   input logic [LANES-1:0]        req_ready,
   input logic [LANES*ADDR_W-1:0] req_addr,
   input logic [LANES-1:0]        rsp_valid,
   input logic [LANES-1:0]        lane_full,
   input logic [LANES*cnt_bits(DEPTH)-1:0] lane_credit,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [LANES*LANE_W-1:0] out_data
);

   localparam int unsigned CW = cnt_bits(DEPTH);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_chk
         AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_valid[l] && !req_ready[l] |=> req_valid[l]); // R1
         AST_REQ_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            req_valid[l] && !req_ready[l] |=> $stable(req_addr[l*ADDR_W +: ADDR_W])); // R1
         AST_CREDIT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lane_credit[l*CW +: CW] <= CW'(DEPTH)); // R3
         AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rsp_valid[l] |-> !lane_full[l]); // R4
      end
   endgenerate

   AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

endmodule

bind rd_lane_mover rd_lane_mover_chk #(
   .LANES  (LANES),
   .LANE_W (LANE_W),
   .ADDR_W (ADDR_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid   (mem_req_valid_o),
   .req_ready   (mem_req_ready_i),
   .req_addr    (mem_req_addr_o),
   .rsp_valid   (mem_rsp_valid_i),
   .lane_full   (lane_full),
   .lane_credit (lane_credit),
   .out_valid   (out_valid_o),
   .out_ready   (out_ready_i),
   .out_data    (out_data_o)
);

// File: tb/rd_lane_mover_test.sv
module rd_lane_mover_test;

   localparam int LANES  = 4;
   localparam int LANE_W = 16;
   localparam int ADDR_W = 16;
   localparam int DEPTH  = 4;
   localparam int SW     = LANE_W / 8;
   localparam int NSTEPS = 12;
   localparam longint LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                    step_valid;
   logic                    step_ready;
   logic [LANES*ADDR_W-1:0] step_addr;
   logic [LANES*ADDR_W-1:0] req_addr;
   logic [LANES*LANE_W-1:0] req_wdata;
   logic [LANES-1:0]        req_write;
   logic [LANES*SW-1:0]     req_strb;
   logic [LANES-1:0]        req_valid;
   logic [LANES-1:0]        req_ready;
   logic [LANES*LANE_W-1:0] rsp_data;
   logic [LANES-1:0]        rsp_valid;
   logic [LANES*LANE_W-1:0] out_data;
   logic                    out_valid;
   logic                    out_ready;

   rd_lane_mover #(
      .LANES (LANES), .LANE_W (LANE_W), .ADDR_W (ADDR_W), .DEPTH (DEPTH)
   ) uut (
      .clk_i (clk), .rst_ni (rst_n),
      .step_valid_i (step_valid), .step_ready_o (step_ready), .step_addr_i (step_addr),
      .mem_req_addr_o (req_addr), .mem_req_wdata_o (req_wdata), .mem_req_write_o (req_write),
      .mem_req_strb_o (req_strb), .mem_req_valid_o (req_valid), .mem_req_ready_i (req_ready),
      .mem_rsp_data_i (rsp_data), .mem_rsp_valid_i (rsp_valid),
      .out_data_o (out_data), .out_valid_o (out_valid), .out_ready_i (out_ready)
   );

   int n_vec = 0;
   int n_bad = 0;
   longint cyc = 0;
   longint cfg_start = 0;
   bit timed_out = 0;

   int cfg_base, cfg_ts, cfg_ss, cfg_lat, cfg_rm, cfg_om;
   int steps_acc, n_out;
   int n_iss [LANES];
   int n_rcv [LANES];
   int n_pend [LANES];
   longint q_due [LANES][$];
   logic [LANE_W-1:0] q_dat [LANES][$];
   bit prev_stall [LANES];
   logic [ADDR_W-1:0] prev_addr [LANES];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] addr_of(input int s, input int l);
      return ADDR_W'(cfg_base + s * cfg_ts + l * cfg_ss);
   endfunction

   function automatic logic [LANE_W-1:0] data_of(input logic [ADDR_W-1:0] a, input int l);
      return LANE_W'(a * 3 + l * 16'h1111 + 16'h0a5);
   endfunction

   function automatic bit mem_rdy(input int l);
      case (cfg_rm)
         0: return 1'b1;
         1: return ((cyc + l) % 3) != 0;
         default: return ((cyc * 7 + l * 5) % 5) == 0;
      endcase
   endfunction

   function automatic bit acc_rdy();
      case (cfg_om)
         0: return 1'b1;
         1: return (cyc % 2) == 0;
         2: return (cyc % 4) == 0;
         default: return (cyc - cfg_start) > 40;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step_valid = 1'b0; step_addr = '0; req_ready = '0;
      rsp_valid = '0; rsp_data = '0; out_ready = 1'b0;
      steps_acc = 0; n_out = 0;
      for (int l = 0; l < LANES; l++) begin
         n_iss[l] = 0; n_rcv[l] = 0; n_pend[l] = 0;
         q_due[l].delete(); q_dat[l].delete(); prev_stall[l] = 0;
      end
      repeat (2) @(negedge clk);
      #1;
      chk(req_valid == '0, "R9", "request valid in reset", 64'(req_valid), 0);
      chk(out_valid == 1'b0, "R9", "output valid in reset", 64'(out_valid), 0);
      chk(step_ready == 1'b1, "R9", "step ready in reset", 64'(step_ready), 1);
      rst_n = 1'b1;
   endtask

   task automatic cycle_step();
      bit hs [LANES];
      bit exp_bit;
      logic [LANES*LANE_W-1:0] exp_word;
      @(negedge clk);
      cyc++;
      for (int l = 0; l < LANES; l++) begin
         n_rcv[l] += n_pend[l];
         n_pend[l] = 0;
      end
      step_valid = (steps_acc < NSTEPS);
      for (int l = 0; l < LANES; l++) begin
         step_addr[l*ADDR_W +: ADDR_W] = addr_of(steps_acc, l);
         req_ready[l] = mem_rdy(l);
         if (q_due[l].size() > 0 && q_due[l][0] <= cyc) begin
            rsp_valid[l] = 1'b1;
            rsp_data[l*LANE_W +: LANE_W] = q_dat[l][0];
            void'(q_due[l].pop_front());
            void'(q_dat[l].pop_front());
            n_pend[l] = 1;
         end else begin
            rsp_valid[l] = 1'b0;
            rsp_data[l*LANE_W +: LANE_W] = '0;
         end
      end
      out_ready = acc_rdy();
      #1;
      // R1: a stalled request holds valid and address
      for (int l = 0; l < LANES; l++) begin
         if (prev_stall[l]) begin
            chk(req_valid[l] == 1'b1, "R1", "stalled valid dropped", 64'(req_valid[l]), 1);
            chk(req_addr[l*ADDR_W +: ADDR_W] == prev_addr[l], "R1", "stalled address moved",
                64'(req_addr[l*ADDR_W +: ADDR_W]), 64'(prev_addr[l]));
         end
         prev_stall[l] = req_valid[l] && !req_ready[l];
         prev_addr[l]  = req_addr[l*ADDR_W +: ADDR_W];
      end
      // R3 R5: exact request valid from step and credit counts
      for (int l = 0; l < LANES; l++) begin
         exp_bit = (n_iss[l] < steps_acc) && ((n_iss[l] - n_out) < DEPTH);
         chk(req_valid[l] == exp_bit, "R3", $sformatf("lane %0d request valid", l),
             64'(req_valid[l]), 64'(exp_bit));
         hs[l] = req_valid[l] && req_ready[l];
      end
      exp_bit = 1'b1;
      for (int l = 0; l < LANES; l++) begin
         if (n_iss[l] + int'(hs[l]) < steps_acc) exp_bit = 1'b0;
      end
      chk(step_ready == exp_bit, "R5", "step ready", 64'(step_ready), 64'(exp_bit));
      // R6: output valid when every lane holds a word
      exp_bit = 1'b1;
      for (int l = 0; l < LANES; l++) begin
         if (n_rcv[l] <= n_out) exp_bit = 1'b0;
      end
      chk(out_valid == exp_bit, "R6", "output valid", 64'(out_valid), 64'(exp_bit));
      // R2: request contents
      for (int l = 0; l < LANES; l++) begin
         if (hs[l]) begin
            chk(req_addr[l*ADDR_W +: ADDR_W] == addr_of(n_iss[l], l), "R2",
                $sformatf("lane %0d address", l),
                64'(req_addr[l*ADDR_W +: ADDR_W]), 64'(addr_of(n_iss[l], l)));
            chk(req_write[l] == 1'b0 && req_wdata[l*LANE_W +: LANE_W] == '0 &&
                req_strb[l*SW +: SW] == '1, "R2", "read request fields",
                64'({req_write[l], req_strb[l*SW +: SW]}), 64'({1'b0, {SW{1'b1}}}));
            q_due[l].push_back(cyc + cfg_lat);
            q_dat[l].push_back(data_of(addr_of(n_iss[l], l), l));
            n_iss[l]++;
         end
      end
      // R4 R6 R7: joined word content
      if (out_valid && out_ready) begin
         for (int l = 0; l < LANES; l++) begin
            exp_word[l*LANE_W +: LANE_W] = data_of(addr_of(n_out, l), l);
         end
         chk(out_data == exp_word, "R4 R7", $sformatf("output word %0d", n_out),
             64'(out_data), 64'(exp_word));
         n_out++;
      end
      if (step_valid && step_ready) steps_acc++;
      // R3: saturated lanes under a stalled output
      if (cfg_om == 3 && (cyc - cfg_start) == 40) begin
         for (int l = 0; l < LANES; l++) begin
            chk(n_iss[l] == DEPTH, "R3", $sformatf("lane %0d requests at saturation", l),
                64'(n_iss[l]), 64'(DEPTH));
         end
         chk(req_valid == '0, "R3", "no request at saturation", 64'(req_valid), 0);
      end
      if (cyc > LIMIT) timed_out = 1;
   endtask

   task automatic run_cfg(input int b, input int ts, input int ss,
                          input int lt, input int rm, input int om);
      cfg_base = b; cfg_ts = ts; cfg_ss = ss; cfg_lat = lt; cfg_rm = rm; cfg_om = om;
      do_reset();
      cfg_start = cyc;
      while (n_out < NSTEPS && !timed_out) cycle_step();
      if (!timed_out) begin
         for (int l = 0; l < LANES; l++) begin
            chk(n_iss[l] == NSTEPS, "R2", $sformatf("lane %0d requests per run", l),
                64'(n_iss[l]), 64'(NSTEPS));
         end
         cycle_step();
         chk(out_valid == 1'b0, "R8", "output empty after last pop", 64'(out_valid), 0);
      end
   endtask

   initial begin
      step_valid = 1'b0; step_addr = '0; req_ready = '0;
      rsp_valid = '0; rsp_data = '0; out_ready = 1'b0;
      for (int bi = 0; bi < 2 && !timed_out; bi++)
         for (int ti = 0; ti < 2 && !timed_out; ti++)
            for (int si = 0; si < 2 && !timed_out; si++)
               for (int li = 0; li < 2 && !timed_out; li++)
                  for (int rm = 0; rm < 3 && !timed_out; rm++)
                     for (int om = 0; om < 3 && !timed_out; om++)
                        run_cfg(bi ? 16'hfff0 : 0, ti ? 12 : 1, si ? 3 : 1,
                                li ? 4 : 1, rm, om);
      for (int li = 0; li < 2 && !timed_out; li++)
         for (int rm = 0; rm < 2 && !timed_out; rm++)
            run_cfg(16'h0100, 8, 2, li ? 6 : 1, rm, 3);
      if (timed_out) chk(1'b0, "watchdog", "run did not finish", 64'(cyc), 64'(LIMIT));
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule